// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Register

This block is the arithmetic core of a small accumulator machine. Each cycle it can take an accumulator value, a second operand, an incoming carry and a 4-bit operation code. It returns the 8-bit result at once, along with a strobe that says whether the accumulator should take that result. At the clock edge it also updates a held 8-bit flag byte.

The covered operations are:

- plain add and add with carry;
- plain subtract, subtract with borrow, and compare;
- bitwise AND, OR and XOR;
- two's-complement negate and bitwise complement of the accumulator;
- forcing the carry flag to one, and inverting it.

Each operation changes its own fixed set of flags and leaves the rest alone. The parity/overflow bit has two meanings: it reports signed overflow after arithmetic and even parity after a logic operation. The add/subtract bit records which kind of arithmetic ran last.

An operation takes effect only while `opValid` is high. The result and the write strobe are combinational. The flag byte changes on the rising clock edge of the cycle in which the operation was presented.

Top module: `accAlu`

## Requirements
- R1: The flag byte resets to 0x00. It changes only on a rising edge where `opValid` is high and the code is a defined operation. Its layout is sign bit 7, zero bit 6, half-carry bit 4, parity/overflow bit 2, subtract bit 1, carry bit 0.
- R2: Operation codes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 negate, 9 complement, 10 set carry, 11 complement carry. `accWrite` is high only while `opValid` is high and the code is 0-3 or 5-9.
- R3: Add forms `accIn + operand`; add with carry also adds `carryIn`. Carry is the carry out of bit 7 and half-carry the carry out of bit 3. Parity/overflow is signed overflow, subtract is cleared, and sign and zero follow the result.
- R4: Subtract forms `accIn - operand`; subtract with borrow also takes away `carryIn`. Compare computes the same difference but leaves `accWrite` low. All three set carry to the borrow out of bit 7 and half-carry to the borrow out of bit 3. They set parity/overflow to signed overflow and the subtract flag to 1, and sign and zero follow the difference.
- R5: AND, OR and XOR set sign and zero from the result and set parity/overflow to 1 when the result has an even number of ones. They clear subtract and carry. Half-carry becomes 1 for AND and 0 for OR and XOR.
- R6: Negate gives `0 - accIn` with the subtract flag rules. Carry is 1 for any nonzero input, and overflow is 1 only for input 0x80.
- R7: Complement gives the bitwise inverse of `accIn`. It sets half-carry and subtract, and keeps sign, zero, parity/overflow and carry.
- R8: Set carry makes carry 1 and clears half-carry and subtract. Complement carry inverts the held carry and clears subtract. Neither touches the other flags.
- R9: Flag bits 5 and 3 are never altered by any operation and keep their reset value.
- R10: Codes 12-15 write nothing and leave the flag byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 4 | Operation selector |
| accIn | input | 8 | Accumulator operand |
| operand | input | 8 | Second operand |
| carryIn | input | 1 | Incoming carry/borrow for the with-carry forms |
| result | output | 8 | Combinational result |
| accWrite | output | 1 | Accumulator should load `result` |
| flags | output | 8 | Registered flag byte |

## Verification
On every cycle, the assertions check these rules:

- the flags hold when there is no valid operation;
- bits 5 and 3 never move;
- the subtract flag follows the kind of arithmetic;
- logic operations clear carry and subtract and report the parity of the result they produced;
- complement and set carry preserve the flags they must not touch;
- compare never asserts the write strobe.

The numeric behaviour can only be shown by the bench's directed scenarios:

- sums and differences;
- carry and half-carry at the nibble and byte edges;
- signed overflow at 0x7F/0x80;
- borrow chaining through `carryIn`;
- negate of 0x00 and 0x80;
- carry inversion against the held flag.

// File: rtl/accAluPkg.sv
package accAluPkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int OPC_W  = 4;
  localparam int MSB    = DATA_W - 1;

  // flag byte bit positions
  localparam int FLG_S  = 7;
  localparam int FLG_Z  = 6;
  localparam int FLG_H  = 4;
  localparam int FLG_PV = 2;
  localparam int FLG_N  = 1;
  localparam int FLG_C  = 0;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_CMP = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_NEG = 4'd8,
    OP_CPL = 4'd9,
    OP_SCF = 4'd10,
    OP_CCF = 4'd11
  } aluOpE;

  typedef enum logic [1:0] {LG_NONE, LG_AND, LG_OR, LG_XOR} logicSelE;

  typedef struct packed {
    logic     load;
    logic     writeAcc;
    logic     arith;
    logic     sub;
    logic     useCarry;
    logic     zeroA;
    logicSelE logicSel;
    logic     cpl;
    logic     scf;
    logic     ccf;
  } aluStbT;
endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import accAluPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [OPC_W-1:0] opCode,
  output aluStbT           stb
);
  always_comb begin
    stb = '0;
    if (opValid) begin
      case (opCode)
        OP_ADD: begin stb.load = 1'b1; stb.writeAcc = 1'b1; stb.arith = 1'b1; end
        OP_ADC: begin stb.load = 1'b1; stb.writeAcc = 1'b1; stb.arith = 1'b1; stb.useCarry = 1'b1; end
        OP_SUB: begin stb.load = 1'b1; stb.writeAcc = 1'b1; stb.arith = 1'b1; stb.sub = 1'b1; end
        OP_SBC: begin stb.load = 1'b1; stb.writeAcc = 1'b1; stb.arith = 1'b1; stb.sub = 1'b1; stb.useCarry = 1'b1; end
        OP_CMP: begin stb.load = 1'b1; stb.arith = 1'b1; stb.sub = 1'b1; end
        OP_AND: begin stb.load = 1'b1; stb.writeAcc = 1'b1; stb.logicSel = LG_AND; end
        OP_OR:  begin stb.load = 1'b1; stb.writeAcc = 1'b1; stb.logicSel = LG_OR; end
        OP_XOR: begin stb.load = 1'b1; stb.writeAcc = 1'b1; stb.logicSel = LG_XOR; end
        OP_NEG: begin stb.load = 1'b1; stb.writeAcc = 1'b1; stb.arith = 1'b1; stb.sub = 1'b1; stb.zeroA = 1'b1; end
        OP_CPL: begin stb.load = 1'b1; stb.writeAcc = 1'b1; stb.cpl = 1'b1; end
        OP_SCF: begin stb.load = 1'b1; stb.scf = 1'b1; end
        OP_CCF: begin stb.load = 1'b1; stb.ccf = 1'b1; end
        default: stb = '0;
      endcase
    end
  end

  // compare must never update the accumulator
  assert_cmp_keeps_acc_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CMP) |-> !stb.writeAcc);

  // nothing happens without a valid operation
  assert_idle_no_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> (!stb.writeAcc && !stb.load));
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import accAluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  aluStbT            stb,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] flagQ
);
  logic [DATA_W-1:0] opA, opB, opBx, arithRes, logicRes;
  logic [DATA_W:0]   fullSum;
  logic [NIB_W:0]    lowSum;
  logic              cinRaw, cinX, carryOut, halfOut, ovf;
  logic [DATA_W-1:0] flagNext;

  // subtraction is done as a + ~b + ~borrow; carries are inverted back to borrows
  always_comb begin
    opA      = stb.zeroA ? '0 : accIn;
    opB      = stb.zeroA ? accIn : operand;
    cinRaw   = stb.useCarry & carryIn;
    opBx     = stb.sub ? ~opB : opB;
    cinX     = stb.sub ? ~cinRaw : cinRaw;
    fullSum  = {1'b0, opA} + {1'b0, opBx} + {{DATA_W{1'b0}}, cinX};
    lowSum   = {1'b0, opA[NIB_W-1:0]} + {1'b0, opBx[NIB_W-1:0]} + {{NIB_W{1'b0}}, cinX};
    arithRes = fullSum[DATA_W-1:0];
    carryOut = fullSum[DATA_W] ^ stb.sub;
    halfOut  = lowSum[NIB_W] ^ stb.sub;
    ovf      = (opA[MSB] == opBx[MSB]) && (arithRes[MSB] != opA[MSB]);
  end

  always_comb begin
    case (stb.logicSel)
      LG_AND:  logicRes = accIn & operand;
      LG_OR:   logicRes = accIn | operand;
      LG_XOR:  logicRes = accIn ^ operand;
      default: logicRes = accIn;
    endcase
    if (stb.arith)                    result = arithRes;
    else if (stb.logicSel != LG_NONE) result = logicRes;
    else if (stb.cpl)                 result = ~accIn;
    else                              result = accIn;
  end

  always_comb begin
    flagNext = flagQ;
    if (stb.arith) begin
      flagNext[FLG_S]  = result[MSB];
      flagNext[FLG_Z]  = (result == '0);
      flagNext[FLG_H]  = halfOut;
      flagNext[FLG_PV] = ovf;
      flagNext[FLG_N]  = stb.sub;
      flagNext[FLG_C]  = carryOut;
    end else if (stb.logicSel != LG_NONE) begin
      flagNext[FLG_S]  = result[MSB];
      flagNext[FLG_Z]  = (result == '0);
      flagNext[FLG_H]  = (stb.logicSel == LG_AND);
      flagNext[FLG_PV] = ~^result;
      flagNext[FLG_N]  = 1'b0;
      flagNext[FLG_C]  = 1'b0;
    end else if (stb.cpl) begin
      flagNext[FLG_H]  = 1'b1;
      flagNext[FLG_N]  = 1'b1;
    end else if (stb.scf) begin
      flagNext[FLG_C]  = 1'b1;
      flagNext[FLG_H]  = 1'b0;
      flagNext[FLG_N]  = 1'b0;
    end else if (stb.ccf) begin
      flagNext[FLG_C]  = ~flagQ[FLG_C];
      flagNext[FLG_N]  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         flagQ <= '0;
    else if (stb.load) flagQ <= flagNext;
  end

  assert_flags_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(flagQ));

  assert_spare_bits_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable({flagQ[5], flagQ[3]}));

  assert_add_clears_n_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.arith && !stb.sub) |=> !flagQ[FLG_N]);

  assert_sub_sets_n_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.arith && stb.sub) |=> flagQ[FLG_N]);

  assert_logic_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.logicSel != LG_NONE) |=>
      (!flagQ[FLG_C] && !flagQ[FLG_N] && flagQ[FLG_PV] == $past(~^result)));

  assert_cpl_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.cpl) |=>
      (flagQ[FLG_H] && flagQ[FLG_N] &&
       {flagQ[FLG_S], flagQ[FLG_Z], flagQ[FLG_PV], flagQ[FLG_C]} ==
       $past({flagQ[FLG_S], flagQ[FLG_Z], flagQ[FLG_PV], flagQ[FLG_C]})));

  assert_scf_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.scf) |=>
      (flagQ[FLG_C] && !flagQ[FLG_H] && !flagQ[FLG_N] &&
       {flagQ[FLG_S], flagQ[FLG_Z], flagQ[FLG_PV]} ==
       $past({flagQ[FLG_S], flagQ[FLG_Z], flagQ[FLG_PV]})));
endmodule

// File: rtl/accAlu.sv
module accAlu
  import accAluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OPC_W-1:0]  opCode,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              accWrite,
  output logic [DATA_W-1:0] flags
);
  aluStbT stb;

  aluCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .stb(stb)
  );

  aluDatapath dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .accIn(accIn), .operand(operand),
    .carryIn(carryIn), .result(result), .flagQ(flags)
  );

  assign accWrite = stb.writeAcc;
endmodule

// File: tb/accAlu_tb_top.sv
`timescale 1ns/1ps
module accAlu_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opCode = 4'd0;
  logic [7:0] accIn = 8'd0;
  logic [7:0] operand = 8'd0;
  logic       carryIn = 1'b0;
  logic [7:0] result;
  logic       accWrite;
  logic [7:0] flags;

  int checks = 0;
  int errors = 0;
  logic [7:0] expFlags = 8'h00;

  always #5 clk = ~clk;

  accAlu dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .accIn(accIn),
    .operand(operand), .carryIn(carryIn), .result(result), .accWrite(accWrite),
    .flags(flags)
  );

  task automatic checkVal(input string req, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference behaviour written from the requirements
  task automatic model(input logic [3:0] code, input logic [7:0] a, b, input logic ci,
                       input logic [7:0] fIn, output logic [7:0] r,
                       output logic wr, output logic [7:0] fOut);
    int s, lo;
    fOut = fIn; r = a; wr = 1'b1;
    case (code)
      4'd0, 4'd1: begin
        s  = int'(a) + int'(b) + ((code == 4'd1) ? int'(ci) : 0);
        lo = int'(a & 8'h0F) + int'(b & 8'h0F) + ((code == 4'd1) ? int'(ci) : 0);
        r  = s[7:0];
        fOut[0] = s > 255; fOut[4] = lo > 15; fOut[1] = 1'b0;
        fOut[2] = (a[7] == b[7]) && (r[7] != a[7]);
        fOut[7] = r[7]; fOut[6] = (r == 8'h00);
      end
      4'd2, 4'd3, 4'd4, 4'd8: begin
        logic [7:0] x, y;
        x = (code == 4'd8) ? 8'h00 : a;
        y = (code == 4'd8) ? a : b;
        s  = int'(x) - int'(y) - ((code == 4'd3) ? int'(ci) : 0);
        lo = int'(x & 8'h0F) - int'(y & 8'h0F) - ((code == 4'd3) ? int'(ci) : 0);
        r  = s[7:0];
        fOut[0] = s < 0; fOut[4] = lo < 0; fOut[1] = 1'b1;
        fOut[2] = (x[7] != y[7]) && (r[7] != x[7]);
        fOut[7] = r[7]; fOut[6] = (r == 8'h00);
        if (code == 4'd4) wr = 1'b0;
      end
      4'd5, 4'd6, 4'd7: begin
        r = (code == 4'd5) ? (a & b) : (code == 4'd6) ? (a | b) : (a ^ b);
        fOut[7] = r[7]; fOut[6] = (r == 8'h00); fOut[4] = (code == 4'd5);
        fOut[2] = ~^r; fOut[1] = 1'b0; fOut[0] = 1'b0;
      end
      4'd9:  begin r = ~a; fOut[4] = 1'b1; fOut[1] = 1'b1; end
      4'd10: begin wr = 1'b0; fOut[0] = 1'b1; fOut[4] = 1'b0; fOut[1] = 1'b0; end
      4'd11: begin wr = 1'b0; fOut[0] = ~fIn[0]; fOut[1] = 1'b0; end
      default: wr = 1'b0;
    endcase
  endtask

  task automatic runOp(input string req, input logic [3:0] code,
                       input logic [7:0] a, b, input logic ci);
    logic [7:0] er, nf;
    logic ew;
    model(code, a, b, ci, expFlags, er, ew, nf);
    @(negedge clk);
    opValid = 1'b1; opCode = code; accIn = a; operand = b; carryIn = ci;
    #1;
    checkVal(req, "accWrite", {7'd0, accWrite}, {7'd0, ew});
    if (ew) checkVal(req, "result", result, er);
    @(negedge clk);
    opValid = 1'b0;
    expFlags = nf;
    #1 checkVal(req, "flags", flags, expFlags);
  endtask

  task automatic testReset();
    #1 checkVal("R1", "reset flags", flags, 8'h00);
    checkVal("R2", "reset accWrite", {7'd0, accWrite}, 8'h00);
  endtask

  task automatic testAdd();
    runOp("R3", 4'd0, 8'h0F, 8'h01, 1'b1);
    runOp("R3", 4'd0, 8'h7F, 8'h01, 1'b0);
    runOp("R3", 4'd0, 8'hFF, 8'h01, 1'b0);
    runOp("R3", 4'd1, 8'h10, 8'h20, 1'b1);
    runOp("R3", 4'd1, 8'h80, 8'h80, 1'b0);
  endtask

  task automatic testSub();
    runOp("R4", 4'd2, 8'h00, 8'h01, 1'b0);
    runOp("R4", 4'd2, 8'h80, 8'h01, 1'b1);
    runOp("R4", 4'd3, 8'h05, 8'h05, 1'b1);
    runOp("R4", 4'd3, 8'h50, 8'h20, 1'b0);
    runOp("R4", 4'd4, 8'h42, 8'h42, 1'b0);
    runOp("R4", 4'd4, 8'h10, 8'h90, 1'b0);
  endtask

  task automatic testLogic();
    runOp("R5", 4'd5, 8'hF0, 8'h3C, 1'b0);
    runOp("R5", 4'd6, 8'h01, 8'h02, 1'b0);
    runOp("R5", 4'd7, 8'hAA, 8'hAA, 1'b0);
    runOp("R5", 4'd7, 8'h80, 8'h00, 1'b0);
  endtask

  task automatic testNeg();
    runOp("R6", 4'd8, 8'h00, 8'h00, 1'b0);
    runOp("R6", 4'd8, 8'h80, 8'h00, 1'b0);
    runOp("R6", 4'd8, 8'h01, 8'h00, 1'b0);
  endtask

  task automatic testCplAndCarry();
    runOp("R7", 4'd9, 8'h5A, 8'h00, 1'b0);
    runOp("R8", 4'd10, 8'h00, 8'h00, 1'b0);
    runOp("R8", 4'd11, 8'h00, 8'h00, 1'b0);
    runOp("R8", 4'd11, 8'h00, 8'h00, 1'b0);
    checkVal("R9", "spare bits", flags & 8'h28, 8'h00);
  endtask

  task automatic testIdleAndUnused();
    @(negedge clk);
    opValid = 1'b0; opCode = 4'd5; accIn = 8'h00; operand = 8'h00;
    #1 checkVal("R2", "idle accWrite", {7'd0, accWrite}, 8'h00);
    @(negedge clk);
    #1 checkVal("R1", "idle flags", flags, expFlags);
    for (int c = 12; c < 16; c++) runOp("R10", 4'(c), 8'hFF, 8'h01, 1'b1);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    testAdd();
    testSub();
    testLogic();
    testNeg();
    testCplAndCarry();
    testIdleAndUnused();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule